// File: doc/BRIEF.md
# Preemptible Multi-Stage Hardware Task

This block runs a fixed chain of functional units over a set of operands. A start strobe captures all operands into their own registers at once. The units then run one after another, and each unit folds its operand into a single running value held in a middle register. A stage counter picks which unit feeds that register. It also picks the output slot through an address that moves forward by one at every stage. Each unit takes a fixed number of cycles. The moment a unit writes the middle register is the only point at which the task can be interrupted.

A scheduler that wants the datapath for something else raises a preemption request. The request is remembered until the running unit finishes, and the task then stops at that stage boundary. While stopped, the task shows its running value, its stage counter and its output address on dedicated context lines so that software can store them. To continue, software drives a stored context back on the restore lines and pulses a resume strobe. The task loads those three values and carries on from the stage they name. The functional units are placeholder arithmetic stages.

Top module: `hwt_preempt_task`

## Requirements
- R1: While reset is held and after its release, busy_o, preempted_o, stage_done_o and done_o are low, and result_o, ctx_cnt_o and ctx_addr_o are zero.
- R2: When idle, start_i captures operand k from operands_i[k*DATA_W +: DATA_W] for each of the N_UNITS units. It clears the running value to 0, sets the stage counter to 0 and sets the address to start_addr_i. Unit k turns running value m into ((m rotated left by one bit) XOR operand k) + (k+1), modulo 2^DATA_W.
- R3: Every stage lasts STAGE_LAT cycles. At the end of a stage, result_o takes the unit's output and stage_done_o pulses for one cycle. stage_addr_o shows the address used by that stage, and ctx_addr_o and ctx_cnt_o each advance by one. An uninterrupted run raises done_o, together with stage_done_o, on the N_UNITS*STAGE_LAT-th clock edge after the start edge, and busy_o falls in that same cycle.
- R4: A preemption request that arrives during a stage, before that stage's last cycle, is held pending. preempted_o rises only together with the stage_done_o of the stage that is running. At that point ctx_cnt_o names the next stage to run, and result_o shows the value that stage wrote.
- R5: A preemption request sampled on the very edge on which a stage ends is honoured at that boundary.
- R6: While preempted_o is high, result_o, ctx_cnt_o and ctx_addr_o hold their values, no stage_done_o occurs, and the flag stays high until resume_i.
- R7: resume_i while preempted loads rest_data_i, rest_cnt_i and rest_addr_i as the running value, stage counter and address. It clears preempted_o, and the run continues from stage rest_cnt_i, which is clamped to N_UNITS-1. Restoring a saved context gives the same final result as an uninterrupted run.
- R8: start_i is ignored while busy, including while preempted: the operands and the context are kept. resume_i is ignored unless the task is preempted. A preemption request is neither acted on nor remembered while idle or while already preempted.
- R9: A request that is pending at, or arrives on, the final stage's boundary does not preempt. The task completes and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken when idle |
| start_addr_i | input | ADDR_W | First output address of a run |
| operands_i | input | N_UNITS*DATA_W | Operand k at bits k*DATA_W upward |
| preempt_req_i | input | 1 | Preemption request |
| resume_i | input | 1 | Resume strobe, taken when preempted |
| rest_data_i | input | DATA_W | Running value to restore |
| rest_cnt_i | input | CNT_W | Stage counter to restore |
| rest_addr_i | input | ADDR_W | Output address to restore |
| busy_o | output | 1 | Task active (running or preempted) |
| preempted_o | output | 1 | Task stopped at a stage boundary |
| stage_done_o | output | 1 | One-cycle pulse when a middle-register write occurs |
| stage_addr_o | output | ADDR_W | Address used by the stage that just ended |
| done_o | output | 1 | One-cycle pulse when the last stage ends |
| result_o | output | DATA_W | Middle register: running or stored value |
| ctx_cnt_o | output | CNT_W | Stage counter for context saving |
| ctx_addr_o | output | ADDR_W | Output address for context saving |

## Verification
The bench runs three kinds of job. An uninterrupted run checks the chained arithmetic and the stage timing against a directly computed result. A run preempted in mid-stage and resumed with its own saved context must reproduce the uninterrupted result, which shows that no state is lost across the stop. A run resumed with a foreign context must finish with the value computed from that context, which shows that the restore lines really take control. Request timing is then varied in four ways: inside a stage, on a boundary, inside the last stage and on the final boundary. This separates deferred preemption from preemption on the same edge and from a dropped request. Strobes sent while idle or preempted must leave the outputs unchanged.

// File: rtl/hwt_pkg.sv
package hwt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_HELD = 2'd2
    } hwt_phase_e;

endpackage

// File: rtl/hwt_in_bank.sv
module hwt_in_bank #(
    parameter int N_UNITS = 4,
    parameter int DATA_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic [N_UNITS*DATA_W-1:0]   ops_i,
    output logic [N_UNITS*DATA_W-1:0]   ops_o
);

    for (genvar g = 0; g < N_UNITS; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (load_i) begin
                slot_q <= ops_i[g*DATA_W +: DATA_W];
            end
        end

        assign ops_o[g*DATA_W +: DATA_W] = slot_q;
    end

endmodule

// File: rtl/hwt_unit.sv
module hwt_unit #(
    parameter int DATA_W = 16,
    parameter int IDX    = 0
) (
    input  logic [DATA_W-1:0] mid_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] res_o
);

    logic [DATA_W-1:0] rot;

    assign rot   = {mid_i[DATA_W-2:0], mid_i[DATA_W-1]};
    assign res_o = (rot ^ opnd_i) + DATA_W'(IDX + 1);

endmodule

// File: rtl/hwt_result_mux.sv
module hwt_result_mux #(
    parameter int N_UNITS = 4,
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 2
) (
    input  logic [N_UNITS*DATA_W-1:0] ys_i,
    input  logic [CNT_W-1:0]          sel_i,
    output logic [DATA_W-1:0]         y_o
);

    always_comb begin
        y_o = '0;
        for (int i = 0; i < N_UNITS; i++) begin
            if (sel_i == CNT_W'(i)) begin
                y_o = ys_i[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/hwt_preempt_task.sv
module hwt_preempt_task
    import hwt_pkg::*;
#(
    parameter int  N_UNITS   = 4,
    parameter int  DATA_W    = 16,
    parameter int  ADDR_W    = 8,
    parameter int  STAGE_LAT = 3,
    localparam int CNT_W     = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [ADDR_W-1:0]           start_addr_i,
    input  logic [N_UNITS*DATA_W-1:0]   operands_i,
    input  logic                        preempt_req_i,
    input  logic                        resume_i,
    input  logic [DATA_W-1:0]           rest_data_i,
    input  logic [CNT_W-1:0]            rest_cnt_i,
    input  logic [ADDR_W-1:0]           rest_addr_i,
    output logic                        busy_o,
    output logic                        preempted_o,
    output logic                        stage_done_o,
    output logic [ADDR_W-1:0]           stage_addr_o,
    output logic                        done_o,
    output logic [DATA_W-1:0]           result_o,
    output logic [CNT_W-1:0]            ctx_cnt_o,
    output logic [ADDR_W-1:0]           ctx_addr_o
);

    localparam int SUB_W = (STAGE_LAT > 1) ? $clog2(STAGE_LAT) : 1;
    localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(STAGE_LAT - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(N_UNITS - 1);

    typedef struct packed {
        hwt_phase_e         phase;
        logic               pend;
        logic [SUB_W-1:0]   sub;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  mid;
        logic               stg;
        logic               fin;
        logic [ADDR_W-1:0]  waddr;
    } task_st_t;

    task_st_t st_d, st_q;

    logic                      take_start;
    logic [N_UNITS*DATA_W-1:0] ops_q;
    logic [N_UNITS*DATA_W-1:0] unit_y;
    logic [DATA_W-1:0]         sel_y;
    logic [CNT_W-1:0]          cnt_load;

    assign take_start = (st_q.phase == PH_IDLE) && start_i;

    hwt_in_bank #(
        .N_UNITS (N_UNITS),
        .DATA_W  (DATA_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (take_start),
        .ops_i  (operands_i),
        .ops_o  (ops_q)
    );

    for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
        hwt_unit #(
            .DATA_W (DATA_W),
            .IDX    (g)
        ) u_unit (
            .mid_i  (st_q.mid),
            .opnd_i (ops_q[g*DATA_W +: DATA_W]),
            .res_o  (unit_y[g*DATA_W +: DATA_W])
        );
    end

    hwt_result_mux #(
        .N_UNITS (N_UNITS),
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W)
    ) u_mux (
        .ys_i  (unit_y),
        .sel_i (st_q.cnt),
        .y_o   (sel_y)
    );

    // Restored stage counter: clamp only when the counter width can
    // encode values beyond the last unit.
    if ((1 << CNT_W) == N_UNITS) begin : g_cnt_exact
        assign cnt_load = rest_cnt_i;
    end else begin : g_cnt_clamp
        assign cnt_load = (rest_cnt_i > LAST_CNT) ? LAST_CNT : rest_cnt_i;
    end

    always_comb begin
        st_d     = st_q;
        st_d.stg = 1'b0;
        st_d.fin = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_RUN;
                    st_d.pend  = 1'b0;
                    st_d.sub   = '0;
                    st_d.cnt   = '0;
                    st_d.addr  = start_addr_i;
                    st_d.mid   = '0;
                end
            end
            PH_RUN: begin
                if (st_q.sub == LAST_SUB) begin
                    // stage boundary: middle-register write
                    st_d.mid   = sel_y;
                    st_d.waddr = st_q.addr;
                    st_d.addr  = st_q.addr + ADDR_W'(1);
                    st_d.sub   = '0;
                    st_d.stg   = 1'b1;
                    st_d.pend  = 1'b0;
                    if (st_q.cnt == LAST_CNT) begin
                        st_d.phase = PH_IDLE;
                        st_d.fin   = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                        if (st_q.pend || preempt_req_i) begin
                            st_d.phase = PH_HELD;
                        end
                    end
                end else begin
                    st_d.sub = st_q.sub + SUB_W'(1);
                    if (preempt_req_i) begin
                        st_d.pend = 1'b1;
                    end
                end
            end
            PH_HELD: begin
                if (resume_i) begin
                    st_d.phase = PH_RUN;
                    st_d.mid   = rest_data_i;
                    st_d.cnt   = cnt_load;
                    st_d.addr  = rest_addr_i;
                    st_d.sub   = '0;
                    st_d.pend  = 1'b0;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o       = (st_q.phase != PH_IDLE);
    assign preempted_o  = (st_q.phase == PH_HELD);
    assign stage_done_o = st_q.stg;
    assign stage_addr_o = st_q.waddr;
    assign done_o       = st_q.fin;
    assign result_o     = st_q.mid;
    assign ctx_cnt_o    = st_q.cnt;
    assign ctx_addr_o   = st_q.addr;

endmodule

// File: rtl/hwt_preempt_task_chk.sv
module hwt_preempt_task_chk #(
    parameter int  N_UNITS = 4,
    parameter int  DATA_W  = 16,
    parameter int  ADDR_W  = 8,
    localparam int CNT_W   = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              resume_i,
    input logic [DATA_W-1:0] rest_data_i,
    input logic [ADDR_W-1:0] rest_addr_i,
    input logic              busy_o,
    input logic              preempted_o,
    input logic              stage_done_o,
    input logic [ADDR_W-1:0] stage_addr_o,
    input logic              done_o,
    input logic [DATA_W-1:0] result_o,
    input logic [CNT_W-1:0]  ctx_cnt_o,
    input logic [ADDR_W-1:0] ctx_addr_o
);

    // R4: preemption only appears at a middle-register write
    a_r4_preempt_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(preempted_o) |-> stage_done_o);

    // R6: context frozen while preempted
    a_r6_context_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (preempted_o && !resume_i) |=> (preempted_o && !stage_done_o &&
            $stable(result_o) && $stable(ctx_cnt_o) && $stable(ctx_addr_o)));

    // R7: resume loads the restore lines
    a_r7_resume_load: assert property (@(posedge clk) disable iff (!rst_n)
        (preempted_o && resume_i) |=> (!preempted_o && busy_o &&
            result_o == $past(rest_data_i) && ctx_addr_o == $past(rest_addr_i)));

    // R3: address advances by one per stage
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        stage_done_o |-> (ctx_addr_o == stage_addr_o + ADDR_W'(1)));

    // R3: completion coincides with the last stage write and ends the task
    a_r3_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (stage_done_o && !busy_o && !preempted_o));

    // R8: start does not disturb a preempted task
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (preempted_o && start_i && !resume_i) |=> (preempted_o && $stable(ctx_addr_o)));

endmodule

bind hwt_preempt_task hwt_preempt_task_chk #(
    .N_UNITS (N_UNITS),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/tb_hwt_preempt_task.sv
module tb_hwt_preempt_task;

    localparam int N   = 4;
    localparam int W   = 16;
    localparam int AW  = 8;
    localparam int LAT = 3;
    localparam int CW  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [AW-1:0]   start_addr_i = '0;
    logic [N*W-1:0]  operands_i = '0;
    logic            preempt_req_i = 1'b0;
    logic            resume_i = 1'b0;
    logic [W-1:0]    rest_data_i = '0;
    logic [CW-1:0]   rest_cnt_i = '0;
    logic [AW-1:0]   rest_addr_i = '0;
    logic            busy_o, preempted_o, stage_done_o, done_o;
    logic [AW-1:0]   stage_addr_o, ctx_addr_o;
    logic [W-1:0]    result_o;
    logic [CW-1:0]   ctx_cnt_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hwt_preempt_task #(
        .N_UNITS (N), .DATA_W (W), .ADDR_W (AW), .STAGE_LAT (LAT)
    ) dut (
        .clk, .rst_n, .start_i, .start_addr_i, .operands_i, .preempt_req_i,
        .resume_i, .rest_data_i, .rest_cnt_i, .rest_addr_i, .busy_o,
        .preempted_o, .stage_done_o, .stage_addr_o, .done_o, .result_o,
        .ctx_cnt_o, .ctx_addr_o
    );

    function automatic logic [W-1:0] unit_op(int k, logic [W-1:0] m, logic [W-1:0] x);
        return ({m[W-2:0], m[W-1]} ^ x) + W'(k + 1);
    endfunction

    function automatic logic [W-1:0] gold(logic [N*W-1:0] ops, int s, logic [W-1:0] m);
        logic [W-1:0] v = m;
        for (int k = s; k < N; k++) v = unit_op(k, v, ops[k*W +: W]);
        return v;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int            m_ph;      // 0 idle, 1 running, 2 held
    bit            m_pend, m_stg, m_fin;
    int            m_sub, m_cnt;
    logic [AW-1:0] m_addr, m_waddr;
    logic [W-1:0]  m_mid;
    logic [N*W-1:0] m_ops;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pend = 0; m_stg = 0; m_fin = 0; m_sub = 0; m_cnt = 0;
            m_addr = '0; m_waddr = '0; m_mid = '0; m_ops = '0;
        end else begin
            m_stg = 0; m_fin = 0;
            if (m_ph == 0) begin
                if (start_i) begin
                    m_ops = operands_i; m_ph = 1; m_pend = 0; m_sub = 0;
                    m_cnt = 0; m_addr = start_addr_i; m_mid = '0;
                end
            end else if (m_ph == 1) begin
                if (m_sub == LAT - 1) begin
                    m_mid = unit_op(m_cnt, m_mid, m_ops[m_cnt*W +: W]);
                    m_waddr = m_addr; m_addr = m_addr + 1'b1; m_sub = 0; m_stg = 1;
                    if (m_cnt == N - 1) begin
                        m_ph = 0; m_fin = 1;
                    end else begin
                        m_cnt++;
                        if (m_pend || preempt_req_i) m_ph = 2;
                    end
                    m_pend = 0;
                end else begin
                    m_sub++;
                    if (preempt_req_i) m_pend = 1;
                end
            end else begin
                if (resume_i) begin
                    m_ph = 1; m_mid = rest_data_i; m_cnt = int'(rest_cnt_i);
                    m_addr = rest_addr_i; m_sub = 0; m_pend = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 busy vs model", busy_o, (m_ph != 0));
            chk("R4 preempted vs model", preempted_o, (m_ph == 2));
            chk("R3 stage_done vs model", stage_done_o, m_stg);
            chk("R3 done vs model", done_o, m_fin);
            chk("R2 result vs model", result_o, m_mid);
            chk("R7 ctx_cnt vs model", ctx_cnt_o, m_cnt);
            chk("R7 ctx_addr vs model", ctx_addr_o, m_addr);
            if (m_stg) chk("R3 stage_addr vs model", stage_addr_o, m_waddr);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic start_task(logic [N*W-1:0] ops, logic [AW-1:0] a);
        @(negedge clk);
        operands_i = ops; start_addr_i = a; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // request sampled on the k-th edge after the current negedge's previous edge
    task automatic pulse_req_at(int k);
        repeat (k - 1) @(negedge clk);
        preempt_req_i = 1'b1;
        @(negedge clk);
        preempt_req_i = 1'b0;
    endtask

    task automatic wait_done(output int cyc, output bit saw_pre);
        cyc = 0; saw_pre = 0;
        while (!done_o && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (preempted_o) saw_pre = 1;
        end
    endtask

    task automatic do_resume(logic [W-1:0] d, logic [CW-1:0] c, logic [AW-1:0] a);
        rest_data_i = d; rest_cnt_i = c; rest_addr_i = a; resume_i = 1'b1;
        @(negedge clk);
        resume_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [N*W-1:0] opa = {16'h0F0F, 16'h1357, 16'hBEEF, 16'h00A5};
        logic [N*W-1:0] opb = {16'h7777, 16'h8001, 16'h4242, 16'hC3C3};
        logic [N*W-1:0] opc = {16'h1111, 16'h2222, 16'h3333, 16'h4444};
        logic [W-1:0]   sv_mid;
        logic [CW-1:0]  sv_cnt;
        logic [AW-1:0]  sv_addr;
        int  cyc;
        bit  saw;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy_o, 0);
        chk("R1 result in reset", result_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 preempted after reset", preempted_o, 0);
        chk("R1 ctx_addr after reset", ctx_addr_o, 0);

        // R2/R3: uninterrupted run
        start_task(opa, 8'h10);
        wait_done(cyc, saw);
        chk("R3 run length", cyc, N * LAT);
        chk("R2 final result", result_o, gold(opa, 0, '0));
        chk("R3 final address", ctx_addr_o, 8'h14);
        chk("R3 busy falls with done", busy_o, 0);

        // R4: mid-stage request is deferred
        start_task(opb, 8'h20);
        pulse_req_at(1);
        chk("R4 no preempt mid-stage", preempted_o, 0);
        repeat (LAT - 1) @(negedge clk);
        chk("R4 preempt at boundary", preempted_o, 1);
        chk("R4 stage_done with preempt", stage_done_o, 1);
        chk("R4 saved counter", ctx_cnt_o, 1);
        chk("R4 saved value", result_o, unit_op(0, '0, opb[0 +: W]));
        sv_mid = result_o; sv_cnt = ctx_cnt_o; sv_addr = ctx_addr_o;
        // R8: start while preempted ignored
        start_task(opc, 8'h99);
        repeat (4) @(negedge clk);
        chk("R6 held value stable", result_o, sv_mid);
        chk("R8 start ignored while preempted", ctx_addr_o, sv_addr);
        chk("R6 still preempted", preempted_o, 1);
        // R8: request while preempted not remembered
        pulse_req_at(1);
        // R7: resume with own context, same result as uninterrupted
        do_resume(sv_mid, sv_cnt, sv_addr);
        wait_done(cyc, saw);
        chk("R7 resumed run length", cyc, (N - 1) * LAT);
        chk("R8 no preempt from request while held", saw, 0);
        chk("R7 resumed result matches uninterrupted", result_o, gold(opb, 0, '0));
        chk("R7 resumed final address", ctx_addr_o, 8'h24);

        // R5: request on the boundary edge, then foreign context swap (R7)
        start_task(opc, 8'h30);
        pulse_req_at(LAT);
        chk("R5 preempt on boundary edge", preempted_o, 1);
        chk("R5 counter after boundary preempt", ctx_cnt_o, 1);
        do_resume(16'h1234, 2'd2, 8'h40);
        wait_done(cyc, saw);
        chk("R7 foreign context length", cyc, 2 * LAT);
        chk("R7 foreign context result", result_o, gold(opc, 2, 16'h1234));
        chk("R7 foreign context address", ctx_addr_o, 8'h42);

        // R8: idle request/resume ignored
        pulse_req_at(1);
        do_resume(16'hDEAD, 2'd1, 8'h77);
        chk("R8 idle stays idle", busy_o, 0);
        chk("R8 idle result untouched", result_o, gold(opc, 2, 16'h1234));
        chk("R8 idle address untouched", ctx_addr_o, 8'h42);
        start_task(opa, 8'h50);
        wait_done(cyc, saw);
        chk("R8 idle request not remembered", saw, 0);
        chk("R8 run after idle request", result_o, gold(opa, 0, '0));

        // R9: pending request in last stage is dropped
        start_task(opb, 8'h60);
        pulse_req_at((N - 1) * LAT + 1);
        wait_done(cyc, saw);
        chk("R9 no preempt from last stage", saw, 0);
        chk("R9 completes", result_o, gold(opb, 0, '0));
        @(negedge clk);
        chk("R9 request dropped", busy_o, 0);

        // R9: request on the final boundary edge
        start_task(opc, 8'h70);
        pulse_req_at(N * LAT);
        chk("R9 done on final boundary", done_o, 1);
        chk("R9 no preempt on final boundary", preempted_o, 0);
        repeat (3) @(negedge clk);
        chk("R9 stays idle", busy_o, 0);

        finish_run();
    end

endmodule